// File: doc/BRIEF.md
# Capture/Compare Channel of a Counter Array

This block is one channel of a programmable counter array. It watches a free-running 16-bit counter that it shares with its sibling channels. It also holds a 16-bit compare/capture register and a 6-bit mode register. The mode bits are independent of each other, so the same hardware can act in several ways. It can latch the counter value when an external input has a rising edge, a falling edge or either edge. It can raise an event flag when the counter reaches a programmed value, which makes it a software timer. It can invert an output pin on a match, which makes it a high-speed output. It can also drive that pin as an 8-bit pulse-width modulator.

Software programs the channel through byte and field write strobes. It reads the registers back through the `*_q` outputs. It clears the event flag by writing zero to it. The flag drives an interrupt request only while the interrupt-enable mode bit is set.

Top module: `ccap_channel`

## Requirements
- R1: After synchronous reset, the mode register, the compare register, the event flag, the output pin and the interrupt request are all zero.
- R2: The mode register is written whole by `mode_we` and is read back on `mode_q`. Its bits are: bit 0 interrupt enable, bit 1 PWM enable, bit 2 toggle-on-match, bit 3 flag-on-match, bit 4 falling-edge capture, bit 5 rising-edge capture.
- R3: With bit 3 set, the flag is set on the clock edge at which the counter equals the compare register. With bit 3 clear, a match leaves the flag unchanged.
- R4: With bit 2 set and bit 1 clear, a match inverts `out_pin` on that clock edge.
- R5: A match acts only on the first cycle of a given counter value. While the counter holds at the compare value, the match does not toggle the pin again and does not set the flag again.
- R6: Capture loads the counter value into the compare register and sets the flag. Bit 5 enables capture on a rising edge of `cap_in` and bit 4 enables it on a falling edge. An edge whose bit is clear is ignored. `cap_in` passes through a two-flop synchronizer, so a change that is set up before clock edge k is captured at edge k+2, using the counter value present at that edge.
- R7: `irq` equals the flag gated by bit 0. The flag still sets when bit 0 is clear.
- R8: Only hardware sets the flag. Only a `flag_we` write with `flag_wdata`=0 clears it, and a write of 1 has no effect. When a hardware set and a software clear fall in the same cycle, the set wins.
- R9: With bit 1 set, `out_pin` is registered. At each edge it takes the value 0 if the counter low byte is below the compare low byte, and 1 otherwise.
- R10: With bit 1 set, the compare low byte is reloaded from the compare high byte at the edge where the counter low byte is 0xFF. A write to the high byte therefore changes the duty cycle only at that reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_val | input | 16 | Shared counter value |
| cap_in | input | 1 | Asynchronous capture input |
| mode_we | input | 1 | Mode register write strobe |
| mode_wdata | input | 6 | Mode register write data |
| cmp_lo_we | input | 1 | Compare low-byte write strobe |
| cmp_hi_we | input | 1 | Compare high-byte write strobe |
| cmp_wdata | input | 8 | Compare byte write data |
| flag_we | input | 1 | Event flag write strobe |
| flag_wdata | input | 1 | Event flag write data (0 clears) |
| out_pin | output | 1 | Channel output pin |
| mode_q | output | 6 | Mode register readback |
| cmp_q | output | 16 | Compare/capture register readback |
| flag_q | output | 1 | Event flag |
| irq | output | 1 | Interrupt request |

## Verification
Two functions can fall in the same cycle: a hardware event setting the flag, and software writing zero to clear it. The bench provokes this by presenting the counter's match value on the same clock edge that carries the flag-clear write. The flag must read 1 afterwards. A related case has the counter hold at the match value after a clear. There the flag and the pin must stay put, which shows that a stalled counter produces no second event.

// File: rtl/ccap_pkg.sv
package ccap_pkg;
    localparam int CNT_W  = 16;
    localparam int BYTE_W = CNT_W / 2;
    localparam int MODE_W = 6;

    typedef struct packed {
        logic cap_pos;   // bit 5
        logic cap_neg;   // bit 4
        logic mat;       // bit 3
        logic tog;       // bit 2
        logic pwm;       // bit 1
        logic irq_en;    // bit 0
    } mode_t;

    function automatic logic pwm_level(input logic [BYTE_W-1:0] cnt_lo,
                                       input logic [BYTE_W-1:0] thr);
        return cnt_lo >= thr;
    endfunction
endpackage

// File: rtl/ccap_sync_edge.sv
module ccap_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise,
    output logic fall
);
    logic [STAGES:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-1:0], din};
    end

    assign rise = sh[STAGES-1] & ~sh[STAGES];
    assign fall = ~sh[STAGES-1] & sh[STAGES];
endmodule

// File: rtl/ccap_match.sv
module ccap_match #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] cmp,
    output logic         match_ev
);
    logic [W-1:0] prev_cnt;
    logic         prev_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_cnt   <= '0;
            prev_valid <= 1'b0;
        end else begin
            prev_cnt   <= cnt;
            prev_valid <= 1'b1;
        end
    end

    assign match_ev = (cnt == cmp) && (!prev_valid || (cnt != prev_cnt));
endmodule

// File: rtl/ccap_channel.sv
module ccap_channel
    import ccap_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CNT_W-1:0]  cnt_val,
    input  logic              cap_in,
    input  logic              mode_we,
    input  logic [MODE_W-1:0] mode_wdata,
    input  logic              cmp_lo_we,
    input  logic              cmp_hi_we,
    input  logic [BYTE_W-1:0] cmp_wdata,
    input  logic              flag_we,
    input  logic              flag_wdata,
    output logic              out_pin,
    output logic [MODE_W-1:0] mode_q,
    output logic [CNT_W-1:0]  cmp_q,
    output logic              flag_q,
    output logic              irq
);
    mode_t             mode_r;
    logic [BYTE_W-1:0] cmp_lo, cmp_hi;
    logic              flag_r, out_r;
    logic              rise, fall, cap_ev, match_ev, reload, hw_set;
    logic [BYTE_W-1:0] cnt_lo, cnt_hi;

    assign cnt_lo = cnt_val[BYTE_W-1:0];
    assign cnt_hi = cnt_val[CNT_W-1:BYTE_W];

    ccap_sync_edge #(.STAGES(SYNC_STAGES)) edge_i (
        .clk(clk), .rst(rst), .din(cap_in), .rise(rise), .fall(fall)
    );

    ccap_match #(.W(CNT_W)) match_i (
        .clk(clk), .rst(rst), .cnt(cnt_val), .cmp({cmp_hi, cmp_lo}),
        .match_ev(match_ev)
    );

    assign cap_ev = (rise & mode_r.cap_pos) | (fall & mode_r.cap_neg);
    assign reload = mode_r.pwm && (cnt_lo == {BYTE_W{1'b1}});
    assign hw_set = cap_ev | (match_ev & mode_r.mat);

    always_ff @(posedge clk) begin
        if (rst)          mode_r <= '0;
        else if (mode_we) mode_r <= mode_t'(mode_wdata);
    end

    // Compare register: capture > PWM reload > bus write
    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_lo <= '0;
            cmp_hi <= '0;
        end else begin
            if (cap_ev)         cmp_lo <= cnt_lo;
            else if (reload)    cmp_lo <= cmp_hi;
            else if (cmp_lo_we) cmp_lo <= cmp_wdata;

            if (cap_ev)         cmp_hi <= cnt_hi;
            else if (cmp_hi_we) cmp_hi <= cmp_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                         flag_r <= 1'b0;
        else if (hw_set)                 flag_r <= 1'b1;
        else if (flag_we && !flag_wdata) flag_r <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)                        out_r <= 1'b0;
        else if (mode_r.pwm)            out_r <= pwm_level(cnt_lo, cmp_lo);
        else if (match_ev && mode_r.tog) out_r <= ~out_r;
    end

    assign out_pin = out_r;
    assign mode_q  = mode_r;
    assign cmp_q   = {cmp_hi, cmp_lo};
    assign flag_q  = flag_r;
    assign irq     = flag_r & mode_r.irq_en;

    // ---------------- assertions ----------------
    logic armed;
    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    assert_match_flag_R3: assert property (@(posedge clk) disable iff (rst)
        (match_ev && mode_r.mat) |=> flag_q);

    assert_toggle_R4: assert property (@(posedge clk) disable iff (rst)
        (match_ev && mode_r.tog && !mode_r.pwm && !mode_we) |=> (out_pin != $past(out_pin)));

    assert_no_retrigger_R5: assert property (@(posedge clk) disable iff (rst)
        (armed && cnt_val == $past(cnt_val)) |-> !match_ev);

    assert_capture_load_R6: assert property (@(posedge clk) disable iff (rst)
        cap_ev |=> (cmp_q == $past(cnt_val)));

    assert_irq_gate_R7: assert property (@(posedge clk) disable iff (rst)
        !mode_q[0] |-> !irq);

    assert_flag_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !(flag_we && !flag_wdata)) |=> flag_q);

    assert_pwm_reload_R10: assert property (@(posedge clk) disable iff (rst)
        (mode_r.pwm && cnt_lo == {BYTE_W{1'b1}} && !cap_ev) |=> (cmp_q[BYTE_W-1:0] == $past(cmp_hi)));
endmodule

// File: tb/ccap_channel_tb.sv
module ccap_channel_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NPWM = 7;
    // {compare high byte, counter low byte, expected pin}
    localparam logic [16:0] PWM_VEC [NPWM] = '{
        {8'h80, 8'h7F, 1'b0},
        {8'h80, 8'h80, 1'b1},
        {8'h00, 8'h00, 1'b1},
        {8'hFF, 8'hFE, 1'b0},
        {8'hFF, 8'hFF, 1'b1},
        {8'h40, 8'hC0, 1'b1},
        {8'h40, 8'h3F, 1'b0}
    };

    logic        clk = 1'b0, rst = 1'b1;
    logic [15:0] cnt_val = '0;
    logic        cap_in = 1'b0, mode_we = 1'b0, cmp_lo_we = 1'b0, cmp_hi_we = 1'b0;
    logic [5:0]  mode_wdata = '0;
    logic [7:0]  cmp_wdata = '0;
    logic        flag_we = 1'b0, flag_wdata = 1'b0;
    logic        out_pin, flag_q, irq;
    logic [5:0]  mode_q;
    logic [15:0] cmp_q;
    int          n_run = 0, n_fail = 0;
    logic        done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ccap_channel dut_i (
        .clk(clk), .rst(rst), .cnt_val(cnt_val), .cap_in(cap_in),
        .mode_we(mode_we), .mode_wdata(mode_wdata),
        .cmp_lo_we(cmp_lo_we), .cmp_hi_we(cmp_hi_we), .cmp_wdata(cmp_wdata),
        .flag_we(flag_we), .flag_wdata(flag_wdata),
        .out_pin(out_pin), .mode_q(mode_q), .cmp_q(cmp_q),
        .flag_q(flag_q), .irq(irq)
    );

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic set_mode(input logic [5:0] m);
        mode_wdata = m; mode_we = 1'b1;
        step();
        mode_we = 1'b0;
    endtask

    task automatic write_cmp(input logic [15:0] v);
        cmp_wdata = v[7:0]; cmp_lo_we = 1'b1; step(); cmp_lo_we = 1'b0;
        cmp_wdata = v[15:8]; cmp_hi_we = 1'b1; step(); cmp_hi_we = 1'b0;
    endtask

    task automatic clear_flag();
        flag_we = 1'b1; flag_wdata = 1'b0; step(); flag_we = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        step(2);
        chk("R1 mode", mode_q, 0);
        chk("R1 cmp", cmp_q, 0);
        chk("R1 flag", flag_q, 0);
        chk("R1 pin", out_pin, 0);
        chk("R1 irq", irq, 0);
        rst = 1'b0;
        step();

        // R2 readback
        set_mode(6'b101101);
        chk("R2 mode readback", mode_q, 6'b101101);

        // Timer: flag on match
        set_mode(6'h08);
        write_cmp(16'h1234);
        chk("R2 cmp write", cmp_q, 16'h1234);
        cnt_val = 16'h1233; step();
        chk("R3 no match", flag_q, 0);
        cnt_val = 16'h1234; step();
        chk("R3 match sets flag", flag_q, 1);
        chk("R7 irq gated off", irq, 0);
        set_mode(6'h09);
        chk("R7 irq enabled", irq, 1);
        clear_flag();
        chk("R8 clear by zero / R5 stall", flag_q, 0);
        flag_we = 1'b1; flag_wdata = 1'b1; step(); flag_we = 1'b0;
        chk("R8 write one ignored", flag_q, 0);
        set_mode(6'h00);
        cnt_val = 16'h0000; step();
        cnt_val = 16'h1234; step();
        chk("R3 mat clear no flag", flag_q, 0);

        // Toggle on match
        set_mode(6'h04);
        cnt_val = 16'h1233; step();
        chk("R4 pin before", out_pin, 0);
        cnt_val = 16'h1234; step();
        chk("R4 toggle", out_pin, 1);
        step(3);
        chk("R5 stalled counter", out_pin, 1);
        cnt_val = 16'h1235; step();
        cnt_val = 16'h1234; step();
        chk("R4 toggle back", out_pin, 0);

        // Same-cycle set and clear
        set_mode(6'h08);
        cnt_val = 16'h1233; step();
        cnt_val = 16'h1234; flag_we = 1'b1; flag_wdata = 1'b0; step(); flag_we = 1'b0;
        chk("R8 set wins over clear", flag_q, 1);
        clear_flag();

        // Capture
        set_mode(6'h20);
        cnt_val = 16'hABCD; cap_in = 1'b1; step(4);
        chk("R6 rising capture", cmp_q, 16'hABCD);
        chk("R6 capture flag", flag_q, 1);
        clear_flag();
        cnt_val = 16'h1111; cap_in = 1'b0; step(4);
        chk("R6 falling ignored", cmp_q, 16'hABCD);
        chk("R6 falling no flag", flag_q, 0);
        set_mode(6'h10);
        cnt_val = 16'h2222; cap_in = 1'b1; step(4);
        chk("R6 rising ignored", cmp_q, 16'hABCD);
        cap_in = 1'b0; step(4);
        chk("R6 falling capture", cmp_q, 16'h2222);
        set_mode(6'h30);
        cnt_val = 16'h3333; cap_in = 1'b1; step(4);
        chk("R6 both rising", cmp_q, 16'h3333);
        cnt_val = 16'h4444; cap_in = 1'b0; step(4);
        chk("R6 both falling", cmp_q, 16'h4444);
        cnt_val = 16'h5555; cap_in = 1'b1; step(2);
        chk("R6 sync latency not yet", cmp_q, 16'h4444);
        step();
        chk("R6 sync latency loaded", cmp_q, 16'h5555);
        step(2);

        // PWM table
        set_mode(6'h02);
        for (int i = 0; i < NPWM; i++) begin
            cnt_val = 16'h0010;
            cmp_wdata = PWM_VEC[i][16:9]; cmp_hi_we = 1'b1; step(); cmp_hi_we = 1'b0;
            cnt_val = 16'h00FF; step();
            chk("R10 reload", cmp_q[7:0], PWM_VEC[i][16:9]);
            cnt_val = {8'h00, PWM_VEC[i][8:1]}; step();
            chk("R9 pwm level", out_pin, PWM_VEC[i][0]);
        end
        // Glitch-free: high-byte write waits for reload (threshold now 0x40)
        cnt_val = 16'h0050;
        cmp_wdata = 8'hC0; cmp_hi_we = 1'b1; step(); cmp_hi_we = 1'b0;
        step();
        chk("R10 no early reload", cmp_q[7:0], 8'h40);
        chk("R9 old threshold", out_pin, 1);
        cnt_val = 16'h00FF; step();
        cnt_val = 16'h0050; step();
        chk("R10 new threshold", out_pin, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule